// File: doc/BRIEF.md
# UART transmit count and ready control

This block is the register-facing half of a UART transmitter. Software first programs how many characters the next transfer carries, then writes the characters one at a time into a small transmit queue. The queue feeds a bit-level serializer, which appears here as a plain valid/ready byte sink. Every byte the serializer takes lowers the remaining count by one.

The block has two status bits. The transmitter-empty bit is set whenever the queue holds nothing. The transmit-ready interrupt bit latches when the programmed count runs out, and it stays set until software sends a clear command. Software may write another character when either bit is set.

A command write can also flush the transmit side completely. Another command code sends a one-cycle reset pulse towards the receiver.

Top module: `uart_tx_ctrl`

## Requirements
- R1: After reset, status bit 3 reads 1, interrupt bit 7 reads 0, the remaining count reads 0, ser_valid is 0 and rx_reset_o is 0.
- R2: A write with wr_sel=0 loads the remaining count from wr_data[CNT_W-1:0]. The new value is visible on tx_left_o after the next clock edge.
- R3: A write with wr_sel=1 queues wr_data[7:0]. Queued bytes appear on ser_data in the order they were written. ser_valid is high while the queue is not empty, and a byte leaves the queue on a cycle where ser_valid and ser_ready are both high.
- R4: A queue write made while the queue holds DEPTH bytes is dropped. That byte never reaches ser_data.
- R5: Each byte the serializer accepts lowers the remaining count by one. The count stays at 0 once it gets there.
- R6: Interrupt bit 7 (the transmit-ready flag) sets on the same edge on which an accepted byte takes the count from 1 to 0.
- R7: A write with wr_sel=2 and wr_data[11:8]=3 clears the transmit-ready flag. If the flag is being set on that same edge, the set wins.
- R8: Status bit 3 (transmitter empty) is 1 exactly when the queue holds no bytes.
- R9: A write with wr_sel=2 and wr_data[7:4]=2 flushes the queue, zeroes the remaining count and clears the transmit-ready flag.
- R10: A write with wr_sel=2 and wr_data[7:4]=1 drives rx_reset_o high for exactly the cycle after the write. It leaves the transmit side unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 queue, 2 command |
| wr_data | input | DATA_W | Write data |
| ser_valid | output | 1 | A byte is offered to the serializer |
| ser_data | output | 8 | Byte at the head of the queue |
| ser_ready | input | 1 | Serializer takes the offered byte |
| status_o | output | 8 | Status word; bit 3 is transmitter empty |
| isr_o | output | 8 | Interrupt status word; bit 7 is transmit ready |
| tx_left_o | output | CNT_W | Remaining character count |
| rx_reset_o | output | 1 | One-cycle receiver reset pulse |

## Verification
The assertions assume that at most one register write arrives per cycle, and that a command word carries a single action. The checks of count stepping and of ready setting also assume that no count load happens on the same edge as the serializer accepting a byte.

The vector table keeps to these assumptions. It issues one write or one idle step per cycle, and it raises ser_ready only on steps where it loads no count. The only deliberate overlap in the table is a clear command issued on the same edge as the draining accept, which is there to show that the set wins.

// File: rtl/uartx_pkg.sv
package uartx_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_QUEUE = 2'd1,
    SEL_CMD   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int STS_EMPTY_BIT = 3;
  localparam int ISR_READY_BIT = 7;

  localparam logic [3:0] CMDH_CLR_READY = 4'h3;
  localparam logic [3:0] CMDL_TX_RESET  = 4'h2;
  localparam logic [3:0] CMDL_RX_RESET  = 4'h1;
endpackage

// File: rtl/uartx_cmd_dec.sv
module uartx_cmd_dec
  import uartx_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [3:0] cmd_hi,
  input  logic [3:0] cmd_lo,
  output logic       cnt_wr,
  output logic       queue_wr,
  output logic       clr_ready,
  output logic       tx_reset,
  output logic       rx_reset
);
  logic cmd_wr;

  always_comb begin
    cnt_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
    queue_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_QUEUE);
    cmd_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD);
    clr_ready = cmd_wr && (cmd_hi == CMDH_CLR_READY);
    tx_reset  = cmd_wr && (cmd_lo == CMDL_TX_RESET);
    rx_reset  = cmd_wr && (cmd_lo == CMDL_RX_RESET);
  end
endmodule

// File: rtl/uartx_fifo.sv
module uartx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uartx_txcount.sv
module uartx_txcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  input  logic             clr,
  output logic [CNT_W-1:0] left,
  output logic             ready,
  output logic             drain_hit
);
  function automatic logic [CNT_W-1:0] left_after(input logic [CNT_W-1:0] cur,
                                                   input logic take_byte);
    return (take_byte && cur != '0) ? cur - 1'b1 : cur;
  endfunction

  assign drain_hit = take && !load && (left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left  <= '0;
      ready <= 1'b0;
    end else if (flush) begin
      left  <= '0;
      ready <= 1'b0;
    end else begin
      left <= load ? load_val : left_after(left, take);
      if (drain_hit)  ready <= 1'b1;
      else if (clr)   ready <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uartx_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ser_valid,
  output logic [7:0]        ser_data,
  input  logic              ser_ready,
  output logic [7:0]        status_o,
  output logic [7:0]        isr_o,
  output logic [CNT_W-1:0]  tx_left_o,
  output logic              rx_reset_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          cnt_wr_w, queue_wr_w, clr_w, tx_rst_w, rx_rst_w;
  logic          pop_w, q_empty, q_full, ready_w, drain_hit_w, rx_q;
  logic [LW-1:0] q_level;

  uartx_cmd_dec u_dec (
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .cmd_hi    (wr_data[11:8]),
    .cmd_lo    (wr_data[7:4]),
    .cnt_wr    (cnt_wr_w),
    .queue_wr  (queue_wr_w),
    .clr_ready (clr_w),
    .tx_reset  (tx_rst_w),
    .rx_reset  (rx_rst_w)
  );

  assign ser_valid = !q_empty;
  assign pop_w     = ser_valid && ser_ready;

  uartx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_rst_w),
    .push  (queue_wr_w),
    .din   (wr_data[7:0]),
    .pop   (pop_w),
    .dout  (ser_data),
    .empty (q_empty),
    .full  (q_full),
    .level (q_level)
  );

  uartx_txcount #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_rst_w),
    .load      (cnt_wr_w),
    .load_val  (wr_data[CNT_W-1:0]),
    .take      (pop_w),
    .clr       (clr_w),
    .left      (tx_left_o),
    .ready     (ready_w),
    .drain_hit (drain_hit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= rx_rst_w;
  end
  assign rx_reset_o = rx_q;

  always_comb begin
    status_o = '0;
    status_o[STS_EMPTY_BIT] = q_empty;
    isr_o = '0;
    isr_o[ISR_READY_BIT] = ready_w;
  end
endmodule

// File: rtl/uart_tx_ctrl_chk.sv
module uart_tx_ctrl_chk #(
  parameter int CNT_W = 16,
  parameter int LW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic             queue_wr,
  input logic             clr,
  input logic             tx_rst,
  input logic             rx_rst,
  input logic             pop,
  input logic             full,
  input logic             empty,
  input logic [LW-1:0]    level,
  input logic [CNT_W-1:0] left,
  input logic             ready,
  input logic             rx_out
);
  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (empty && !ready && left == '0)); // R9
  AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && queue_wr && !pop && !tx_rst) |=> $stable(level)); // R4
  AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && left != '0 && !cnt_wr && !tx_rst) |=> (left == $past(left) - 1'b1)); // R5
  AST_LEFT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0 && !cnt_wr && !tx_rst) |=> (left == '0)); // R5
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && left == CNT_W'(1) && !cnt_wr && !tx_rst) |=> ready); // R6
  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pop && !tx_rst) |=> !ready); // R7
  AST_EMPTY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(1) && pop && !queue_wr) |=> empty); // R8
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> rx_out); // R10
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rst |=> !rx_out); // R10
endmodule

bind uart_tx_ctrl uart_tx_ctrl_chk #(.CNT_W(CNT_W), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_wr   (cnt_wr_w),
  .queue_wr (queue_wr_w),
  .clr      (clr_w),
  .tx_rst   (tx_rst_w),
  .rx_rst   (rx_rst_w),
  .pop      (pop_w),
  .full     (q_full),
  .empty    (q_empty),
  .level    (q_level),
  .left     (tx_left_o),
  .ready    (ready_w),
  .rx_out   (rx_reset_o)
);

// File: tb/tb_uart_tx_ctrl.sv
`timescale 1ns/1ps
module tb_uart_tx_ctrl;
  localparam logic [1:0] OP_CNT = 2'd0, OP_Q = 2'd1, OP_CMD = 2'd2, OP_NOP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] data;
    logic        rdy;
    logic        chk;
    logic        exp_v;
    logic [7:0]  exp_d;
    logic        e_empty;
    logic        e_rdy;
    logic [15:0] e_left;
    logic        e_rx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t [0:NV-1] VECS = '{
    '{OP_CNT, 16'h0003, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd3, 1'b0, 4'd2},  // R2
    '{OP_Q,   16'h00A1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd3, 1'b0, 4'd8},  // R8
    '{OP_Q,   16'h00B2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd3, 1'b0, 4'd3},
    '{OP_Q,   16'h00C3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd3, 1'b0, 4'd3},
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hA1, 1'b0, 1'b0, 16'd2, 1'b0, 4'd5},  // R5
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hB2, 1'b0, 1'b0, 16'd1, 1'b0, 4'd3},  // R3
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, 16'd0, 1'b0, 4'd6},  // R6
    '{OP_CMD, 16'h0300, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd0, 1'b0, 4'd7},  // R7
    '{OP_CNT, 16'h0002, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd2, 1'b0, 4'd2},
    '{OP_Q,   16'h0011, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd2, 1'b0, 4'd3},
    '{OP_Q,   16'h0022, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd2, 1'b0, 4'd3},
    '{OP_Q,   16'h0033, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd2, 1'b0, 4'd3},
    '{OP_Q,   16'h0044, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd2, 1'b0, 4'd3},
    '{OP_Q,   16'h0055, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd2, 1'b0, 4'd4},  // R4
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 16'd1, 1'b0, 4'd3},
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'h22, 1'b0, 1'b1, 16'd0, 1'b0, 4'd6},
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'h33, 1'b0, 1'b1, 16'd0, 1'b0, 4'd5},
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'h44, 1'b1, 1'b1, 16'd0, 1'b0, 4'd8},
    '{OP_NOP, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 16'd0, 1'b0, 4'd4},  // R4 0x55 dropped
    '{OP_CMD, 16'h0300, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd0, 1'b0, 4'd7},
    '{OP_CNT, 16'h0005, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd5, 1'b0, 4'd2},
    '{OP_Q,   16'h0066, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd5, 1'b0, 4'd3},
    '{OP_Q,   16'h0077, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd5, 1'b0, 4'd3},
    '{OP_CMD, 16'h0020, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd0, 1'b0, 4'd9},  // R9
    '{OP_NOP, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 16'd0, 1'b0, 4'd9},
    '{OP_CNT, 16'h0001, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd1, 1'b0, 4'd2},
    '{OP_Q,   16'h0088, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd1, 1'b0, 4'd3},
    '{OP_CMD, 16'h0300, 1'b1, 1'b1, 1'b1, 8'h88, 1'b1, 1'b1, 16'd0, 1'b0, 4'd7},  // R7 set wins
    '{OP_CMD, 16'h0020, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd0, 1'b0, 4'd9},
    '{OP_Q,   16'h0099, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd0, 1'b0, 4'd3},
    '{OP_CMD, 16'h0010, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd0, 1'b1, 4'd10}, // R10
    '{OP_NOP, 16'h0000, 1'b1, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0, 16'd0, 1'b0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = OP_NOP;
  logic [15:0] wr_data = '0;
  logic        ser_ready = 1'b0;
  logic        ser_valid;
  logic [7:0]  ser_data, status_o, isr_o;
  logic [15:0] tx_left_o;
  logic        rx_reset_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
    .status_o(status_o), .isr_o(isr_o), .tx_left_o(tx_left_o), .rx_reset_o(rx_reset_o)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle_state(input int req);
    check(status_o == 8'h08, req, "status", status_o, 8'h08);
    check(isr_o == 8'h00, req, "isr", isr_o, 8'h00);
    check(tx_left_o == 16'd0, req, "left", tx_left_o, 0);
    check(ser_valid == 1'b0, req, "ser_valid", ser_valid, 0);
    check(rx_reset_o == 1'b0, req, "rx_reset", rx_reset_o, 0);
  endtask

  task automatic run_vec(input vec_t v);
    wr_en     = (v.op != OP_NOP);
    wr_sel    = v.op;
    wr_data   = v.data;
    ser_ready = v.rdy;
    #1;
    if (v.chk) begin
      check(ser_valid == v.exp_v, v.req, "ser_valid", ser_valid, v.exp_v);
      if (v.exp_v) check(ser_data == v.exp_d, v.req, "ser_data", ser_data, v.exp_d);
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    wr_sel = OP_NOP;
    ser_ready = 1'b0;
    check(status_o == {4'b0, v.e_empty, 3'b0}, v.req, "status", status_o, {4'b0, v.e_empty, 3'b0});
    check(isr_o == {v.e_rdy, 7'b0}, v.req, "isr", isr_o, {v.e_rdy, 7'b0});
    check(tx_left_o == v.e_left, v.req, "left", tx_left_o, v.e_left);
    check(rx_reset_o == v.e_rx, v.req, "rx_reset", rx_reset_o, v.e_rx);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle_state(1); // R1 while held in reset
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_state(1); // R1 after release
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // R1: reset in the middle of a transfer returns the idle state
    run_vec('{OP_CNT, 16'h0009, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'd9, 1'b0, 4'd2});
    run_vec('{OP_Q, 16'h00AA, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'd9, 1'b0, 4'd3});
    rst_n = 1'b0;
    #1;
    check_idle_state(1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_state(1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule